// File: doc/BRIEF.md
# Edge-Triggered Interrupt Bank

This block turns the synchronized levels of one bank of general-purpose pins into a single interrupt request. Each pin has a two-bit trigger selector that picks rising edges, falling edges, both, or nothing. A detected edge sets a sticky pending bit for that pin. The bank interrupt is high while any pending bit is set whose mask bit is clear.

Software reaches the block through a small register port with three word addresses. One address holds the pending bits, and writing ones there clears them. A second address sets mask bits for every one written. A third address clears mask bits for every one written. Software clears a pending bit before it services the pin. An edge that arrives in the same cycle as that clear is therefore kept, so no event is lost. Pending bits latch whether or not the pin is masked.

Top module: `edge_irq_bank`

## Requirements
- R1: While reset is active, every pending bit reads 0, every mask bit reads 1, and `irq` is 0.
- R2: With selector code 1, a pin's pending bit sets on the clock edge that first samples the pin at 1 after it was 0. A 1-to-0 change does not set it.
- R3: With selector code 2, a pin's pending bit sets when the pin changes from 1 to 0. A 0-to-1 change does not set it.
- R4: With selector code 3, a pin's pending bit sets on either change of level.
- R5: With selector code 0, a pin's pending bit never sets, whatever the pin does.
- R6: A write to the pending address (byte offset 0x080 + 4×BANK_IDX) clears each pending bit whose data bit is 1. Bits written 0 keep their value.
- R7: When a new edge and a clearing write hit the same pin in the same cycle, the pending bit stays 1.
- R8: A write to the mask-set address (0x0A0 + 4×BANK_IDX) sets each mask bit whose data bit is 1. A write to the mask-clear address (0x0C0 + 4×BANK_IDX) clears each mask bit whose data bit is 1. Bits written 0 are unchanged.
- R9: `irq` equals the OR over all pins of (pending AND NOT mask). It follows the registered state in the same cycle.
- R10: Pending bits latch while masked, and they only fall through a clearing write.
- R11: A read at the pending address returns the pending bits. A read at either mask address returns the mask bits. A read at any other address returns 0. Pin i is data bit i.
- R12: A write to any other address changes neither pending nor mask bits.
- R13: The first clock edge after reset only captures pin levels. A pin that is already high when reset ends is not an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | NUM_PINS | Synchronized pin levels |
| trig_sel | input | 2*NUM_PINS | Per-pin trigger code, pin i at bits 2i+1:2i (0 off, 1 rise, 2 fall, 3 both) |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data |
| irq | output | 1 | Bank interrupt request |

## Verification
An edge presented before a clock edge is captured by that edge. The pending bit and `irq` are therefore visible one cycle after the pin change. Writes take effect at that same clock edge, and reads are combinational from the registered state. The bench drives all inputs just after a falling clock edge. It advances the reference model at the rising edge, and it compares `irq` and the read data at the next falling edge, so each result is checked in the first cycle it is due. The case where a clear and an edge arrive together, and the capture-only first cycle after reset, are driven on purpose on those exact cycles.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

   typedef enum logic [1:0] {
      TRIG_OFF  = 2'd0,
      TRIG_RISE = 2'd1,
      TRIG_FALL = 2'd2,
      TRIG_BOTH = 2'd3
   } trig_mode_e;

   typedef enum logic [1:0] {
      RSEL_NONE = 2'd0,
      RSEL_PEND = 2'd1,
      RSEL_MASK = 2'd2
   } rd_sel_e;

   // Decide whether a level change matches the selected trigger.
   function automatic logic trig_match(input logic prev_lvl,
                                       input logic cur_lvl,
                                       input trig_mode_e mode);
      logic rise;
      logic fall;
      rise = ~prev_lvl & cur_lvl;
      fall = prev_lvl & ~cur_lvl;
      case (mode)
         TRIG_RISE: trig_match = rise;
         TRIG_FALL: trig_match = fall;
         TRIG_BOTH: trig_match = rise | fall;
         default:   trig_match = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/edge_irq_detect.sv
module edge_irq_detect
   import edge_irq_pkg::*;
#(
   parameter int NUM_PINS = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_PINS-1:0]   pin_lvl,
   input  logic [2*NUM_PINS-1:0] trig_sel,
   output logic [NUM_PINS-1:0]   hit
);

   logic [NUM_PINS-1:0] prev_q;
   logic                armed_q;

   // The first edge after reset only loads the previous-level register.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         armed_q <= 1'b0;
      end else begin
         prev_q  <= pin_lvl;
         armed_q <= 1'b1;
      end
   end

   for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_lane
      trig_mode_e lane_mode;
      assign lane_mode = trig_mode_e'(trig_sel[2*gi +: 2]);
      assign hit[gi]   = armed_q & trig_match(prev_q[gi], pin_lvl[gi], lane_mode);
   end

endmodule

// File: rtl/edge_irq_decode.sv
module edge_irq_decode
   import edge_irq_pkg::*;
#(
   parameter int              ADDR_W    = 12,
   parameter int              BANK_IDX  = 0,
   parameter logic [ADDR_W-1:0] PEND_BASE = 12'h080,
   parameter logic [ADDR_W-1:0] MSET_BASE = 12'h0A0,
   parameter logic [ADDR_W-1:0] MCLR_BASE = 12'h0C0
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   output logic              wr_pend,
   output logic              wr_mset,
   output logic              wr_mclr,
   output rd_sel_e           rd_sel
);

   localparam logic [ADDR_W-1:0] BANK_OFS  = ADDR_W'(BANK_IDX * 4);
   localparam logic [ADDR_W-1:0] PEND_ADDR = PEND_BASE + BANK_OFS;
   localparam logic [ADDR_W-1:0] MSET_ADDR = MSET_BASE + BANK_OFS;
   localparam logic [ADDR_W-1:0] MCLR_ADDR = MCLR_BASE + BANK_OFS;

   logic is_pend, is_mset, is_mclr;

   assign is_pend = (bus_addr == PEND_ADDR);
   assign is_mset = (bus_addr == MSET_ADDR);
   assign is_mclr = (bus_addr == MCLR_ADDR);

   assign wr_pend = bus_wr & is_pend;
   assign wr_mset = bus_wr & is_mset;
   assign wr_mclr = bus_wr & is_mclr;

   always_comb begin
      if (is_pend)                rd_sel = RSEL_PEND;
      else if (is_mset | is_mclr) rd_sel = RSEL_MASK;
      else                        rd_sel = RSEL_NONE;
   end

endmodule

// File: rtl/edge_irq_pend.sv
module edge_irq_pend #(
   parameter int NUM_PINS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] hit,
   input  logic                clr_en,
   input  logic [NUM_PINS-1:0] clr_bits,
   output logic [NUM_PINS-1:0] pend
);

   for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_bit
      logic pend_q;
      // A new edge overrides a clear in the same cycle.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pend_q <= 1'b0;
         else if (hit[gi])
            pend_q <= 1'b1;
         else if (clr_en && clr_bits[gi])
            pend_q <= 1'b0;
      end
      assign pend[gi] = pend_q;
   end

endmodule

// File: rtl/edge_irq_mask.sv
module edge_irq_mask #(
   parameter int NUM_PINS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                set_en,
   input  logic                clr_en,
   input  logic [NUM_PINS-1:0] wbits,
   output logic [NUM_PINS-1:0] mask
);

   for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_bit
      logic mask_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mask_q <= 1'b1;
         else if (set_en && wbits[gi])
            mask_q <= 1'b1;
         else if (clr_en && wbits[gi])
            mask_q <= 1'b0;
      end
      assign mask[gi] = mask_q;
   end

endmodule

// File: rtl/edge_irq_bank.sv
module edge_irq_bank
   import edge_irq_pkg::*;
#(
   parameter int NUM_PINS = 32,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 12,
   parameter int BANK_IDX = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_PINS-1:0]   pin_lvl,
   input  logic [2*NUM_PINS-1:0] trig_sel,
   input  logic                  bus_wr,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   output logic                  irq
);

   localparam int PAD_W = DATA_W - NUM_PINS;

   if (NUM_PINS < 1 || NUM_PINS > DATA_W) begin : g_bad_pins
      $error("edge_irq_bank: NUM_PINS must be 1..DATA_W");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("edge_irq_bank: ADDR_W too small for the register offsets");
   end
   if ((BANK_IDX * 4 + 32'h0C0) >= (1 << ADDR_W)) begin : g_bad_bank
      $error("edge_irq_bank: BANK_IDX places registers outside ADDR_W");
   end

   logic [NUM_PINS-1:0] hit;
   logic [NUM_PINS-1:0] pend_q;
   logic [NUM_PINS-1:0] mask_q;
   logic [NUM_PINS-1:0] wbits;
   logic                wr_pend, wr_mset, wr_mclr;
   rd_sel_e             rd_sel;
   logic [NUM_PINS-1:0] rd_lane;

   assign wbits = bus_wdata[NUM_PINS-1:0];

   edge_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_lvl  (pin_lvl),
      .trig_sel (trig_sel),
      .hit      (hit)
   );

   edge_irq_decode #(.ADDR_W(ADDR_W), .BANK_IDX(BANK_IDX)) u_decode (
      .bus_addr (bus_addr),
      .bus_wr   (bus_wr),
      .wr_pend  (wr_pend),
      .wr_mset  (wr_mset),
      .wr_mclr  (wr_mclr),
      .rd_sel   (rd_sel)
   );

   edge_irq_pend #(.NUM_PINS(NUM_PINS)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit),
      .clr_en   (wr_pend),
      .clr_bits (wbits),
      .pend     (pend_q)
   );

   edge_irq_mask #(.NUM_PINS(NUM_PINS)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (wr_mset),
      .clr_en (wr_mclr),
      .wbits  (wbits),
      .mask   (mask_q)
   );

   always_comb begin
      case (rd_sel)
         RSEL_PEND: rd_lane = pend_q;
         RSEL_MASK: rd_lane = mask_q;
         default:   rd_lane = '0;
      endcase
   end

   if (PAD_W > 0) begin : g_pad
      assign bus_rdata = {{PAD_W{1'b0}}, rd_lane};
   end else begin : g_nopad
      assign bus_rdata = rd_lane;
   end

   assign irq = |(pend_q & ~mask_q);

endmodule

// File: rtl/edge_irq_bank_chk.sv
module edge_irq_bank_chk #(
   parameter int NUM_PINS = 32,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 12,
   parameter int BANK_IDX = 0
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NUM_PINS-1:0]   pin_lvl,
   input logic [2*NUM_PINS-1:0] trig_sel,
   input logic                  bus_wr,
   input logic [ADDR_W-1:0]     bus_addr,
   input logic [DATA_W-1:0]     bus_wdata,
   input logic                  irq,
   input logic [NUM_PINS-1:0]   pend_q,
   input logic [NUM_PINS-1:0]   mask_q
);

   localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(32'h080 + BANK_IDX * 4);
   localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(32'h0A0 + BANK_IDX * 4);
   localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(32'h0C0 + BANK_IDX * 4);

   logic [NUM_PINS-1:0] off_lane;
   for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_off
      assign off_lane[gi] = (trig_sel[2*gi +: 2] == 2'd0);
   end

   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> (pend_q == '0 && mask_q == '1));

   // R5
   off_lane_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & ~$past(pend_q) & $past(off_lane)) == '0));

   // R6
   pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_PEND && pin_lvl == $past(pin_lvl))
      |=> ((pend_q & $past(bus_wdata[NUM_PINS-1:0])) == '0));

   // R8
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_MSET)
      |=> ((mask_q & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0])));

   // R8
   mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_MCLR)
      |=> ((mask_q & $past(bus_wdata[NUM_PINS-1:0])) == '0));

   // R10
   pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == A_PEND)
      |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

   // R9
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '1 || pend_q == '0) |-> !irq);

endmodule

bind edge_irq_bank edge_irq_bank_chk #(
   .NUM_PINS (NUM_PINS),
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .BANK_IDX (BANK_IDX)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pin_lvl   (pin_lvl),
   .trig_sel  (trig_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq       (irq),
   .pend_q    (pend_q),
   .mask_q    (mask_q)
);

// File: tb/edge_irq_bank_bench.sv
module edge_irq_bank_bench;

   localparam int N = 32;
   localparam logic [11:0] A_PEND = 12'h080;
   localparam logic [11:0] A_MSET = 12'h0A0;
   localparam logic [11:0] A_MCLR = 12'h0C0;
   localparam logic [11:0] A_OTHR = 12'h0E0;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pins = '0;
   logic [2*N-1:0] sel = '0;
   logic          wr = 1'b0;
   logic [11:0]   addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          irq;

   always #10 clk = ~clk;

   edge_irq_bank u_edge_irq_bank (
      .clk(clk), .rst_n(rst_n), .pin_lvl(pins), .trig_sel(sel),
      .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
      .bus_rdata(rdata), .irq(irq)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [N-1:0] m_pend, m_mask, m_prev;
   bit           m_armed;

   function automatic logic [N-1:0] exp_hits(input logic [N-1:0] p,
                                             input logic [N-1:0] c,
                                             input logic [2*N-1:0] s);
      logic [N-1:0] h;
      for (int i = 0; i < N; i++) begin
         case (s[2*i +: 2])
            2'd1:    h[i] = ~p[i] & c[i];
            2'd2:    h[i] = p[i] & ~c[i];
            2'd3:    h[i] = p[i] ^ c[i];
            default: h[i] = 1'b0;
         endcase
      end
      return h;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic [N-1:0] p, input bit w,
                       input logic [11:0] a, input logic [31:0] d);
      logic [N-1:0] e;
      pins = p; wr = w; addr = a; wdata = d;
      e = m_armed ? exp_hits(m_prev, p, sel) : '0;
      @(posedge clk);
      if (w && a == A_PEND) m_pend = m_pend & ~d;
      m_pend = m_pend | e;
      if (w && a == A_MSET) m_mask = m_mask | d;
      if (w && a == A_MCLR) m_mask = m_mask & ~d;
      m_prev = p;
      m_armed = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic look(input string req);
      addr = A_PEND; #1;
      chk({req, " pending"}, rdata, m_pend);
      addr = A_MSET; #1;
      chk({req, " mask"}, rdata, m_mask);
      chk({req, " irq"}, {31'd0, irq}, {31'd0, |(m_pend & ~m_mask)});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1234_5678));
      m_pend = '0; m_mask = '1; m_prev = '0; m_armed = 1'b0;
      pins = '1; sel = '1;
      repeat (3) @(negedge clk);
      // R1 reset state
      look("R1");
      rst_n = 1'b1;
      // R13 pins already high at release are not edges
      step('1, 0, A_OTHR, 0);
      step('1, 0, A_OTHR, 0);
      look("R13");
      // R8 unmask everything
      step('1, 1, A_MCLR, 32'hFFFF_FFFF);
      look("R8 clear");
      sel = '0;
      step('0, 0, A_OTHR, 0);
      look("R5 all off");
      // pin0 rise, pin1 fall, pin2 both, pin3 off
      sel = '0;
      sel[1:0] = 2'd1; sel[3:2] = 2'd2; sel[5:4] = 2'd3; sel[7:6] = 2'd0;
      step(32'h0000_000F, 0, A_OTHR, 0);
      look("R2 R4 R5 rise");
      step(32'h0000_0000, 0, A_OTHR, 0);
      look("R3 R4 fall");
      // R6 partial clear
      step(32'h0, 1, A_PEND, 32'h0000_0001);
      look("R6 partial");
      step(32'h0, 1, A_PEND, 32'h0000_0006);
      look("R6 full");
      // R7 edge and clear same cycle on pin0
      step(32'h1, 1, A_PEND, 32'h0000_0001);
      look("R7");
      chk("R7 bit0", {31'd0, m_pend[0]}, 32'd1);
      // R10 masked latch
      step(32'h1, 1, A_MSET, 32'hFFFF_FFFF);
      look("R8 set R9 masked");
      step(32'h0, 0, A_OTHR, 0);
      step(32'h4, 0, A_OTHR, 0);
      look("R10 masked latch");
      step(32'h4, 1, A_MCLR, 32'h0000_0004);
      look("R10 unmask R9");
      // R12 other address write
      step(32'h4, 1, A_OTHR, 32'hFFFF_FFFF);
      look("R12");
      // R11 read decode
      addr = A_MCLR; #1; chk("R11 mask-clear read", rdata, m_mask);
      addr = A_OTHR; #1; chk("R11 other read", rdata, 32'd0);
      // random phase
      for (int k = 0; k < 800; k++) begin
         logic [N-1:0] np;
         logic [11:0]  ra;
         bit           rw;
         if (k % 50 == 0) sel = {$urandom(), $urandom()};
         np = m_prev ^ ($urandom() & $urandom());
         rw = ($urandom() % 4) == 0;
         case ($urandom() % 4)
            0: ra = A_PEND;
            1: ra = A_MSET;
            2: ra = A_MCLR;
            default: ra = A_OTHR;
         endcase
         step(np, rw, ra, $urandom());
         look("R2 R3 R4 R6 R9 random");
      end
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule